// File: doc/BRIEF.md
# Eight-Channel UART Bus Data Loader

This block is the bus-side data path of an eight-channel UART. A 32-bit memory-mapped slave port reaches each channel through two address windows, and each channel owns a transmit byte FIFO and a receive byte FIFO. The byte-wide holding-register address moves one byte per bus operation. A write there puts the low byte lane into the channel's transmit FIFO. A read there removes the oldest byte from the channel's receive FIFO. The burst window takes full 32-bit words. Each word is unpacked, lowest lane first, into four consecutive transmit bytes, so software can fill a whole 64-byte FIFO with sixteen doubleword writes.

Channels sit at a stride of 0x200. For channel k, the holding register is at 0x200*k and the burst window is at 0x100 + 0x200*k. A burst word takes four clock cycles to unpack, and the bus is stalled during that time. Writes that do not fit are dropped and set a sticky per-channel overflow flag. On the serializer side, each channel shows its transmit head byte, its fill count and an empty flag, and takes a pop strobe. That side also pushes received bytes into the channel's receive FIFO.

Top module: `uart_fifo_bus_loader`

## Requirements
- R1: A write to the holding-register offset 0x200*k (k = bus_addr[11:9], bus_addr[8:0] = 0) pushes bus_wdata[7:0] into channel k's transmit FIFO and ignores bits 31:8. bus_ready is high in the same cycle, and no other channel is touched.
- R2: A write to the burst window 0x100 + 0x200*k pushes bits 7:0, 15:8, 23:16 and 31:24 into channel k's transmit FIFO in that order, one byte per cycle. bus_ready stays low for the first three cycles and rises in the fourth.
- R3: Successive burst words continue the byte order across words. The transmit FIFO holds exactly 64 bytes, so sixteen burst words fill it.
- R4: A holding-register write to a full transmit FIFO is dropped in a single cycle. It leaves the count unchanged and sets that channel's tx_ovf bit, which stays set until reset.
- R5: A burst write that arrives when the transmit FIFO has fewer than four free entries is dropped whole. bus_ready is high in its first cycle, no byte is pushed, and tx_ovf is set.
- R6: A read of the holding-register offset returns the oldest receive byte in bus_rdata[7:0], with bits 31:8 zero, in the same cycle, and removes that byte.
- R7: A read of the holding register while the receive FIFO is empty returns 0x00000000 and leaves the FIFO unchanged. The same holds for a tx_pop on an empty transmit FIFO.
- R8: Per channel, tx_count gives the number of bytes held (0 to 64), tx_empty is high when that number is zero, tx_data shows the oldest byte, and tx_pop removes it.
- R9: Any access to another offset (bus_addr[8:0] neither 0x000 nor 0x100), and any read of a burst window, completes in one cycle. It returns zero and changes no FIFO.
- R10: The receive FIFO holds 16 bytes and rx_full goes high when it is full. An rx_push while it is full is discarded.
- R11: After reset, every FIFO is empty, every count is zero and every tx_ovf bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_valid | input | 1 | Bus request present, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request completes this cycle |
| bus_rdata | output | 32 | Read data, valid when bus_ready is high on a read |
| tx_pop | input | 8 | Per-channel pop of the oldest transmit byte |
| tx_data | output | 64 | Per-channel transmit head byte, channel k at [8k+7:8k] |
| tx_count | output | 56 | Per-channel transmit fill count, 7 bits each |
| tx_empty | output | 8 | Per-channel transmit FIFO empty |
| tx_ovf | output | 8 | Per-channel sticky transmit overflow |
| rx_push | input | 8 | Per-channel push of a received byte |
| rx_data | input | 64 | Per-channel received byte, channel k at [8k+7:8k] |
| rx_full | output | 8 | Per-channel receive FIFO full |

## Verification
Holding-register accesses, dropped writes and stray accesses complete in the cycle they are presented. Burst words complete in the fourth cycle. The bench counts the cycles until bus_ready is seen at each falling edge and compares that count with 1 or 4. Counts, flags and head bytes change at the rising edge that ends the transfer, so the bench reads them at the following falling edge. Read data is combinational and is captured at the same falling edge where bus_ready is seen.

// File: rtl/uart_bl_pkg.sv
`timescale 1ns/1ps
package uart_bl_pkg;
  // Kind of access selected by the offset inside a channel's stride.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_HOLD  = 2'd1,
    ACC_BURST = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/uart_bl_fifo.sv
`timescale 1ns/1ps
module uart_bl_fifo #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [7:0]       din_i,
  input  logic             pop_i,
  output logic [7:0]       dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + PTR_W'(1);
    if (do_pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + PTR_W'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; only written slots are ever read.
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  // R4 / R10: the surrounding logic never offers a byte to a full FIFO.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

  // R7: a pop on an empty FIFO with no push leaves it empty.
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);

  // R8: the fill count never exceeds the depth.
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_bl_decode.sv
`timescale 1ns/1ps
module uart_bl_decode
  import uart_bl_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int STRIDE_LOG2 = 9,
  parameter int CH_W        = $clog2(NUM_CH),
  parameter int ADDR_W      = CH_W + STRIDE_LOG2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [CH_W-1:0]   ch_o
);
  localparam logic [STRIDE_LOG2-1:0] HOLD_OFS  = '0;
  localparam logic [STRIDE_LOG2-1:0] BURST_OFS = STRIDE_LOG2'(1) << (STRIDE_LOG2 - 1);

  logic [STRIDE_LOG2-1:0] ofs;

  assign ofs  = addr_i[STRIDE_LOG2-1:0];
  assign ch_o = addr_i[ADDR_W-1:STRIDE_LOG2];

  always_comb begin
    if (ofs == HOLD_OFS)       kind_o = ACC_HOLD;
    else if (ofs == BURST_OFS) kind_o = ACC_BURST;
    else                       kind_o = ACC_NONE;
  end
endmodule

// File: rtl/uart_bl_ctrl.sv
`timescale 1ns/1ps
module uart_bl_ctrl
  import uart_bl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  input  acc_kind_e           kind_i,
  input  logic [CH_W-1:0]     ch_i,
  input  logic [NUM_CH-1:0]   tx_full_i,
  input  logic [NUM_CH-1:0]   tx_room_i,
  input  logic [NUM_CH-1:0]   rx_empty_i,
  input  logic [NUM_CH*8-1:0] rx_head_i,
  output logic                bus_ready_o,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [NUM_CH-1:0]   tx_push_o,
  output logic [7:0]          tx_byte_o,
  output logic [NUM_CH-1:0]   rx_pop_o,
  output logic [NUM_CH-1:0]   ovf_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [NUM_CH-1:0] ovf_q, ovf_d, ovf_set;

  always_comb begin
    lane_d      = lane_q;
    ovf_set     = '0;
    tx_push_o   = '0;
    tx_byte_o   = '0;
    rx_pop_o    = '0;
    bus_ready_o = 1'b0;
    bus_rdata_o = '0;
    if (bus_valid_i) begin
      unique case (kind_i)
        ACC_HOLD: begin
          bus_ready_o = 1'b1;
          if (bus_write_i) begin
            if (tx_full_i[ch_i]) begin
              ovf_set[ch_i] = 1'b1;
            end else begin
              tx_push_o[ch_i] = 1'b1;
              tx_byte_o       = bus_wdata_i[7:0];
            end
          end else if (!rx_empty_i[ch_i]) begin
            rx_pop_o[ch_i] = 1'b1;
            bus_rdata_o    = DATA_W'(rx_head_i[ch_i*8 +: 8]);
          end
        end
        ACC_BURST: begin
          if (!bus_write_i) begin
            bus_ready_o = 1'b1;
          end else if (lane_q == '0 && !tx_room_i[ch_i]) begin
            bus_ready_o   = 1'b1;
            ovf_set[ch_i] = 1'b1;
          end else begin
            tx_push_o[ch_i] = 1'b1;
            tx_byte_o       = bus_wdata_i[lane_q*8 +: 8];
            if (lane_q == LAST_LANE) begin
              bus_ready_o = 1'b1;
              lane_d      = '0;
            end else begin
              lane_d = lane_q + LANE_W'(1);
            end
          end
        end
        default: bus_ready_o = 1'b1;
      endcase
    end
    ovf_d = ovf_q | ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      ovf_q  <= '0;
    end else begin
      lane_q <= lane_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;

  // R2: while a word is being unpacked, the lane index steps by one.
  p_lane_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_write_i && kind_i == ACC_BURST && tx_push_o != '0
     && lane_q != LAST_LANE) |=> lane_q == $past(lane_q) + LANE_W'(1));

  // R2: a burst word is not acknowledged before its last lane is pushed.
  p_burst_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && kind_i == ACC_BURST && tx_push_o != '0 && lane_q != LAST_LANE)
      |-> !bus_ready_o);

  // R4: overflow flags never clear once set.
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_q & $past(ovf_q)) == $past(ovf_q));

  // R7: an empty receive FIFO is read as zero without a pop.
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_write_i && kind_i == ACC_HOLD && rx_empty_i[ch_i])
      |-> (bus_rdata_o == '0 && rx_pop_o == '0));

  // R9: stray offsets complete at once and move no data.
  p_stray_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && kind_i == ACC_NONE)
      |-> (bus_ready_o && tx_push_o == '0 && rx_pop_o == '0 && bus_rdata_o == '0));

  // R2 / R6: at most one FIFO moves a byte per cycle.
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_push_o | rx_pop_o));
endmodule

// File: rtl/uart_fifo_bus_loader.sv
`timescale 1ns/1ps
module uart_fifo_bus_loader
  import uart_bl_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int TX_DEPTH    = 64,
  parameter int RX_DEPTH    = 16,
  parameter int STRIDE_LOG2 = 9,
  parameter int DATA_W      = 32,
  parameter int CH_W        = $clog2(NUM_CH),
  parameter int ADDR_W      = CH_W + STRIDE_LOG2,
  parameter int CNT_W       = $clog2(TX_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic                    bus_ready,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NUM_CH-1:0]       tx_pop,
  output logic [NUM_CH*8-1:0]     tx_data,
  output logic [NUM_CH*CNT_W-1:0] tx_count,
  output logic [NUM_CH-1:0]       tx_empty,
  output logic [NUM_CH-1:0]       tx_ovf,
  input  logic [NUM_CH-1:0]       rx_push,
  input  logic [NUM_CH*8-1:0]     rx_data,
  output logic [NUM_CH-1:0]       rx_full
);
  localparam int LANES   = DATA_W / 8;
  localparam int RX_CW   = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(TX_DEPTH - LANES);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  acc_kind_e           kind;
  logic [CH_W-1:0]     ch;
  logic [NUM_CH-1:0]   tx_full, tx_room, tx_push;
  logic [NUM_CH-1:0]   rx_empty, rx_pop, rx_push_ok;
  logic [NUM_CH*8-1:0] rx_head;
  logic [7:0]          tx_byte;

  uart_bl_decode #(
    .NUM_CH(NUM_CH), .STRIDE_LOG2(STRIDE_LOG2), .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr_i(bus_addr), .kind_o(kind), .ch_o(ch)
  );

  uart_bl_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s2_q),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_wdata_i(bus_wdata),
    .kind_i(kind), .ch_i(ch),
    .tx_full_i(tx_full), .tx_room_i(tx_room),
    .rx_empty_i(rx_empty), .rx_head_i(rx_head),
    .bus_ready_o(bus_ready), .bus_rdata_o(bus_rdata),
    .tx_push_o(tx_push), .tx_byte_o(tx_byte),
    .rx_pop_o(rx_pop), .ovf_o(tx_ovf)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [CNT_W-1:0] tcnt;
    logic [RX_CW-1:0] rcnt;

    uart_bl_fifo #(.DEPTH(TX_DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_s2_q),
      .push_i(tx_push[k]), .din_i(tx_byte), .pop_i(tx_pop[k]),
      .dout_o(tx_data[k*8 +: 8]), .count_o(tcnt),
      .empty_o(tx_empty[k]), .full_o(tx_full[k])
    );

    assign tx_count[k*CNT_W +: CNT_W] = tcnt;
    assign tx_room[k]    = (tcnt <= ROOM_LIM);
    assign rx_push_ok[k] = rx_push[k] & ~rx_full[k];

    uart_bl_fifo #(.DEPTH(RX_DEPTH), .CNT_W(RX_CW)) u_rx (
      .clk(clk), .rst_n(rst_s2_q),
      .push_i(rx_push_ok[k]), .din_i(rx_data[k*8 +: 8]), .pop_i(rx_pop[k]),
      .dout_o(rx_head[k*8 +: 8]), .count_o(rcnt),
      .empty_o(rx_empty[k]), .full_o(rx_full[k])
    );

    // R8: the empty flag and the count agree at the ports.
    p_empty_count_r8: assert property (@(posedge clk) disable iff (!rst_s2_q)
      tx_empty[k] == (tcnt == '0));
  end
endmodule

// File: tb/uart_fifo_bus_loader_test.sv
`timescale 1ns/1ps
module uart_fifo_bus_loader_test;
  localparam int NCH = 8, TXD = 64, RXD = 16, CW = 7, AW = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_valid, bus_write;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic            bus_ready;
  logic [NCH-1:0]  tx_pop, tx_empty, tx_ovf, rx_push, rx_full;
  logic [NCH*8-1:0] tx_data, rx_data;
  logic [NCH*CW-1:0] tx_count;

  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_fifo_bus_loader uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_count(tx_count),
    .tx_empty(tx_empty), .tx_ovf(tx_ovf),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int c, input int i);
    return 8'(c * 53 + i * 7 + 3);
  endfunction

  function automatic int cnt_of(input int c);
    return int'(tx_count[c*CW +: CW]);
  endfunction

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    #1;
    cyc = 1;
    while (!bus_ready) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic txpop(input int c, output logic [7:0] b);
    @(negedge clk);
    b = tx_data[c*8 +: 8];
    tx_pop[c] = 1'b1;
    @(posedge clk);
    #1;
    tx_pop[c] = 1'b0;
  endtask

  task automatic rxput(input int c, input logic [7:0] b);
    @(negedge clk);
    rx_push[c] = 1'b1;
    rx_data[c*8 +: 8] = b;
    @(posedge clk);
    #1;
    rx_push[c] = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    logic [7:0] exp_q [TXD];
    logic [7:0] got;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; tx_pop = '0; rx_push = '0; rx_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk("R11", "tx_empty", tx_empty, {NCH{1'b1}});
    chk("R11", "tx_ovf", tx_ovf, 0);
    chk("R11", "tx_count", tx_count, 0);
    chk("R11", "rx_full", rx_full, 0);

    // R7: pop on empty transmit FIFO changes nothing
    txpop(3, got);
    @(negedge clk);
    chk("R7", "tx count after empty pop", cnt_of(3), 0);

    for (int c = 0; c < NCH; c++) begin
      automatic int n = 0;
      automatic logic [AW-1:0] hold = AW'(c * 512);
      automatic logic [AW-1:0] burst = AW'(c * 512 + 256);
      chk("R4", "ovf before fill", tx_ovf[c], 0);
      if (c % 2 == 0) begin
        // R1: byte write, upper lanes must be ignored
        exp_q[n] = pat(c, n);
        xfer(1'b1, hold, {24'hC35AA5, exp_q[n]}, rd, cyc);
        n++;
        chk("R1", "hold write cycles", cyc, 1);
        @(negedge clk);
        chk("R1", "count after byte", cnt_of(c), 1);
        for (int o = 0; o < NCH; o++)
          if (o != c) chk("R1", "other channel count", cnt_of(o), 0);
      end
      // R2 / R3: fifteen burst words
      for (int w = 0; w < 15; w++) begin
        for (int l = 0; l < 4; l++) exp_q[n + l] = pat(c, n + l);
        xfer(1'b1, burst, {exp_q[n+3], exp_q[n+2], exp_q[n+1], exp_q[n]}, rd, cyc);
        n += 4;
        chk("R2", "burst cycles", cyc, 4);
        @(negedge clk);
        chk("R3", "count after burst", cnt_of(c), n);
      end
      if (c % 2 == 1) begin
        exp_q[n] = pat(c, n);
        xfer(1'b1, hold, {24'h0, exp_q[n]}, rd, cyc);
        n++;
        // R5: only three free, burst dropped whole in one cycle
        xfer(1'b1, burst, 32'hEEEEEEEE, rd, cyc);
        chk("R5", "dropped burst cycles", cyc, 1);
        @(negedge clk);
        chk("R5", "count after dropped burst", cnt_of(c), 61);
        chk("R5", "ovf after dropped burst", tx_ovf[c], 1);
      end
      while (n < TXD) begin
        exp_q[n] = pat(c, n);
        xfer(1'b1, hold, {24'h0, exp_q[n]}, rd, cyc);
        n++;
      end
      @(negedge clk);
      chk("R3", "full count", cnt_of(c), TXD);
      // R4: byte write to full FIFO dropped
      xfer(1'b1, hold, 32'h000000EE, rd, cyc);
      chk("R4", "full write cycles", cyc, 1);
      @(negedge clk);
      chk("R4", "count after drop", cnt_of(c), TXD);
      chk("R4", "ovf set", tx_ovf[c], 1);
      // R8: drain in order
      for (int i = 0; i < TXD; i++) begin
        txpop(c, got);
        chk("R8", "tx byte order", got, exp_q[i]);
      end
      @(negedge clk);
      chk("R8", "empty after drain", tx_empty[c], 1);
      chk("R4", "ovf still set", tx_ovf[c], 1);
    end

    // R6 / R7 / R10: receive path on every channel
    for (int c = 0; c < NCH; c++) begin
      automatic logic [AW-1:0] hold = AW'(c * 512);
      for (int i = 0; i <= RXD; i++) rxput(c, pat(c + 9, i));
      @(negedge clk);
      chk("R10", "rx_full", rx_full[c], 1);
      for (int i = 0; i < RXD; i++) begin
        xfer(1'b0, hold, 32'h0, rd, cyc);
        chk("R6", "rx read data", rd, {24'h0, pat(c + 9, i)});
        chk("R6", "rx read cycles", cyc, 1);
      end
      xfer(1'b0, hold, 32'h0, rd, cyc);
      chk("R7", "empty read", rd, 0);
      xfer(1'b0, hold, 32'h0, rd, cyc);
      chk("R7", "second empty read", rd, 0);
      @(negedge clk);
      chk("R10", "rx_full cleared", rx_full[c], 0);
    end

    // R9: stray offsets and burst-window reads
    rxput(2, 8'h77);
    xfer(1'b1, 12'h404, 32'h11223344, rd, cyc);
    chk("R9", "stray write cycles", cyc, 1);
    xfer(1'b1, 12'h5FC, 32'h55667788, rd, cyc);
    xfer(1'b1, 12'h580, 32'h99AABBCC, rd, cyc);
    xfer(1'b0, 12'h504, 32'h0, rd, cyc);
    chk("R9", "stray read data", rd, 0);
    xfer(1'b0, 12'h500, 32'h0, rd, cyc);
    chk("R9", "burst window read", rd, 0);
    chk("R9", "burst window read cycles", cyc, 1);
    xfer(1'b0, 12'h401, 32'h0, rd, cyc);
    chk("R9", "unaligned read", rd, 0);
    @(negedge clk);
    chk("R9", "tx untouched", tx_count, 0);
    xfer(1'b0, 12'h400, 32'h0, rd, cyc);
    chk("R9", "rx byte kept", rd, 32'h77);

    summary();
    $finish;
  end
endmodule